// File: doc/BRIEF.md
# ROM Download Address Router

This block sits between a host-side loader and the SDRAM write path during ROM installation. The loader presents one byte at a time with a code that names the target ROM, a byte offset inside that ROM and a write strobe. The router turns each accepted byte into a single 16-bit SDRAM write. That write carries a word address, the byte copied onto both halves of the data bus, and a pair of active-high byte masks. The mask leaves exactly one lane enabled.

The code picks a base address. Sprite and voice codes also carry a 512 kB bank number, and the sprite codes add an odd/even word-shift bit. Fix-graphics offsets are reordered so that the pixel pairs of one line share a 16-bit word. Every such byte is written on its own lane and is never merged with a neighbour. The emulated system's core reset is asserted from reset onward and for as long as the download flag is high. It is released on the clock after the flag drops.

Top module: `rom_dl_router`

## Requirements
- R1: Code 4 writes at byte address 0x000000 + offset, code 5 at 0x080000 + offset, and code 6 at 0x200000 + offset.
- R2: Code 0 (system ROM) writes at 0x600000 + offset, and code 2 (system fix ROM) writes at 0x620000 + offset.
- R3: Code 8 writes at 0x680000 + f(offset), where f keeps offset bits above 4 in place and places offset[2:0] at bits 4:2, the inverse of offset[4] at bit 1 and offset[3] at bit 0. For example, f(0x00)=0x02, f(0x08)=0x03, f(0x10)=0x00 and f(0x18)=0x01.
- R4: A code of 64 or more writes at 0x800000 + bank·0x80000 + 2·S + offset, where bank = code[5:1] and S = code[0].
- R5: A code from 16 to 63 writes to voice memory at (code−16)·0x80000 + offset, with `sd_voice`=1. Every other write has `sd_voice`=0.
- R6: Each write has `sd_waddr` = byte address / 2 and `sd_wdata` = {byte, byte}. When the byte address is even, `sd_dqm`=2'b10 (lower lane written). When it is odd, `sd_dqm`=2'b01 (upper lane written).
- R7: Codes 1, 3, 7 and 9 to 15 produce no write.
- R8: A write appears on `sd_we` for exactly the one clock after an edge at which `dl_active` and `dl_wr` are both high with a recognised code. No write appears when either one is low.
- R9: `core_rst_n` is 0 in the clock after any edge at which `dl_active` is high, and 1 in the clock after an edge at which it is low.
- R10: While `rst_n` is low, `sd_we`=0 and `core_rst_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_active | input | 1 | Download in progress |
| dl_index | input | 8 | Target ROM code |
| dl_addr | input | 24 | Byte offset inside the target ROM |
| dl_data | input | 8 | Byte to store |
| dl_wr | input | 1 | Byte strobe |
| sd_we | output | 1 | SDRAM write request |
| sd_voice | output | 1 | Write goes to voice memory |
| sd_waddr | output | 24 | SDRAM word address |
| sd_wdata | output | 16 | Byte copied onto both lanes |
| sd_dqm | output | 2 | Byte masks, 1 = lane masked; bit 0 is the lower lane |
| core_rst_n | output | 1 | Reset to the emulated core, active low |

## Verification
The assertions assume the loader holds `dl_index` and `dl_addr` steady within a strobed cycle. They also assume that offsets never push a sum past the 25-bit byte space, so the word-shift bit reaches the address without a carry interfering. The stimulus keeps every offset below 0x80000, which is inside one bank. It walks all 256 codes against a handful of offsets, and it changes inputs only on falling edges. Each write is followed by an idle cycle, so every past-cycle property sees a single, isolated strobe.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_PROG  = 3'd1,
    RG_SYS   = 3'd2,
    RG_FIX   = 3'd3,
    RG_SPR   = 3'd4,
    RG_VOICE = 3'd5
  } rdr_region_e;
endpackage

// File: rtl/rdr_index_decode.sv
module rdr_index_decode
  import rdr_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int AW      = 25,
  parameter int BANK_SH = 19
) (
  input  logic [IDX_W-1:0] idx,
  output rdr_region_e      region,
  output logic [AW-1:0]    base,
  output logic             word_shift
);
  localparam logic [AW-1:0] PROG0_BASE = AW'(32'h0000000);
  localparam logic [AW-1:0] PROG1_BASE = AW'(32'h0080000);
  localparam logic [AW-1:0] PROG2_BASE = AW'(32'h0200000);
  localparam logic [AW-1:0] SYS_BASE   = AW'(32'h0600000);
  localparam logic [AW-1:0] SFIX_BASE  = AW'(32'h0620000);
  localparam logic [AW-1:0] FIX_BASE   = AW'(32'h0680000);
  localparam logic [AW-1:0] SPR_BASE   = AW'(32'h0800000);
  localparam int            SPR_CODE   = 64;
  localparam int            VOX_CODE   = 16;

  logic [4:0] bank_spr;
  logic [5:0] bank_vox;

  always_comb begin
    bank_spr   = idx[5:1];
    bank_vox   = idx[5:0] - 6'(VOX_CODE);
    region     = RG_NONE;
    base       = '0;
    word_shift = 1'b0;
    if (int'(idx) >= SPR_CODE) begin
      region     = RG_SPR;
      base       = SPR_BASE + (AW'(bank_spr) << BANK_SH);
      word_shift = idx[0];
    end else if (int'(idx) >= VOX_CODE) begin
      region = RG_VOICE;
      base   = AW'(bank_vox) << BANK_SH;
    end else begin
      unique case (idx[3:0])
        4'd0: begin region = RG_SYS;  base = SYS_BASE;   end
        4'd2: begin region = RG_SYS;  base = SFIX_BASE;  end
        4'd4: begin region = RG_PROG; base = PROG0_BASE; end
        4'd5: begin region = RG_PROG; base = PROG1_BASE; end
        4'd6: begin region = RG_PROG; base = PROG2_BASE; end
        4'd8: begin region = RG_FIX;  base = FIX_BASE;   end
        default: begin region = RG_NONE; base = '0; end
      endcase
    end
  end
endmodule

// File: rtl/rdr_fix_remap.sv
module rdr_fix_remap #(
  parameter int W = 24
) (
  input  logic [W-1:0] off_in,
  output logic [W-1:0] off_out
);
  // Line-major order: the three row bits move up, column bits settle low.
  generate
    if (W > 5) begin : g_wide
      assign off_out = {off_in[W-1:5], off_in[2:0], ~off_in[4], off_in[3]};
    end else begin : g_narrow
      assign off_out = off_in;
    end
  endgenerate
endmodule

// File: rtl/rdr_lane_mask.sv
module rdr_lane_mask #(
  parameter int LANES = 2
) (
  input  logic [$clog2(LANES)-1:0] lane_sel,
  output logic [LANES-1:0]         dqm
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dqm[g] = (lane_sel != g[$clog2(LANES)-1:0]);
    end
  endgenerate
endmodule

// File: rtl/rom_dl_router.sv
module rom_dl_router
  import rdr_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DL_AW  = 24,
  parameter int AW     = 25,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dl_active,
  input  logic [IDX_W-1:0]    dl_index,
  input  logic [DL_AW-1:0]    dl_addr,
  input  logic [BYTE_W-1:0]   dl_data,
  input  logic                dl_wr,
  output logic                sd_we,
  output logic                sd_voice,
  output logic [AW-2:0]       sd_waddr,
  output logic [2*BYTE_W-1:0] sd_wdata,
  output logic [1:0]          sd_dqm,
  output logic                core_rst_n
);
  localparam int BANK_SH = 19;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  rdr_region_e       region;
  logic [AW-1:0]     base;
  logic              word_shift;
  logic [DL_AW-1:0]  fix_off;

  rdr_index_decode #(.IDX_W(IDX_W), .AW(AW), .BANK_SH(BANK_SH)) u_dec (
    .idx        (dl_index),
    .region     (region),
    .base       (base),
    .word_shift (word_shift)
  );

  rdr_fix_remap #(.W(DL_AW)) u_fix (
    .off_in  (dl_addr),
    .off_out (fix_off)
  );

  // Next-state logic.
  logic              wr_d;
  logic [AW-1:0]     addr_d;
  logic [DL_AW-1:0]  payload;
  logic              voice_d;

  always_comb begin
    payload = (region == RG_FIX) ? fix_off : dl_addr;
    addr_d  = base + AW'(payload) + (word_shift ? AW'(2) : AW'(0));
    voice_d = (region == RG_VOICE);
    wr_d    = dl_active & dl_wr & (region != RG_NONE);
  end

  // Registers.
  logic              we_q;
  logic              voice_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              core_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      we_q   <= 1'b0;
      core_q <= 1'b0;
    end else begin
      we_q   <= wr_d;
      core_q <= ~dl_active;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      voice_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (wr_d) begin
      voice_q <= voice_d;
      addr_q  <= addr_d;
      data_q  <= dl_data;
    end
  end

  rdr_lane_mask #(.LANES(2)) u_lane (
    .lane_sel (addr_q[0]),
    .dqm      (sd_dqm)
  );

  assign sd_we      = we_q;
  assign sd_voice   = voice_q;
  assign sd_waddr   = addr_q[AW-1:1];
  assign sd_wdata   = {data_q, data_q};
  assign core_rst_n = core_q;

  // Assertions.
  p_single_lane_r6: assert property (@(posedge clk) disable iff (!arst_n)
    sd_we |-> $countones(sd_dqm) == 1);

  p_write_needs_strobe_r8: assert property (@(posedge clk) disable iff (!arst_n)
    sd_we |-> $past(dl_active && dl_wr));

  p_unknown_silent_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (dl_active && dl_wr && int'(dl_index) < 16 &&
     !(dl_index inside {8'd0, 8'd2, 8'd4, 8'd5, 8'd6, 8'd8})) |=> !sd_we);

  p_core_held_r9: assert property (@(posedge clk) disable iff (!arst_n)
    dl_active |=> !core_rst_n);

  p_fix_lane_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (sd_we && $past(dl_index) == 8'd8) |->
      sd_dqm == {~$past(dl_addr[3]), $past(dl_addr[3])});

  p_sprite_shift_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (sd_we && int'($past(dl_index)) >= 64) |->
      sd_waddr[0] == ($past(dl_index[0]) ^ $past(dl_addr[1])));

  p_voice_flag_r5: assert property (@(posedge clk) disable iff (!arst_n)
    sd_we |-> sd_voice == (int'($past(dl_index)) >= 16 && int'($past(dl_index)) < 64));
endmodule

// File: tb/rom_dl_router_bench.sv
module rom_dl_router_bench;
  logic        clk;
  logic        rst_n;
  logic        dl_active;
  logic [7:0]  dl_index;
  logic [23:0] dl_addr;
  logic [7:0]  dl_data;
  logic        dl_wr;
  logic        sd_we;
  logic        sd_voice;
  logic [23:0] sd_waddr;
  logic [15:0] sd_wdata;
  logic [1:0]  sd_dqm;
  logic        core_rst_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rom_dl_router u_rom_dl_router (
    .clk(clk), .rst_n(rst_n), .dl_active(dl_active), .dl_index(dl_index),
    .dl_addr(dl_addr), .dl_data(dl_data), .dl_wr(dl_wr), .sd_we(sd_we),
    .sd_voice(sd_voice), .sd_waddr(sd_waddr), .sd_wdata(sd_wdata),
    .sd_dqm(sd_dqm), .core_rst_n(core_rst_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected byte address; valid=0 means no write, voice marks voice memory.
  function automatic longint exp_byte(int code, longint a, output bit valid, output bit voice);
    valid = 1; voice = 0; exp_byte = 0;
    if (code >= 64) begin
      exp_byte = 64'h800000 + ((code % 64) / 2) * 64'h80000 + (code % 2) * 2 + a;
    end else if (code >= 16) begin
      voice = 1;
      exp_byte = (code - 16) * 64'h80000 + a;
    end else if (code == 4) exp_byte = a;
    else if (code == 5) exp_byte = 64'h080000 + a;
    else if (code == 6) exp_byte = 64'h200000 + a;
    else if (code == 0) exp_byte = 64'h600000 + a;
    else if (code == 2) exp_byte = 64'h620000 + a;
    else if (code == 8)
      exp_byte = 64'h680000 + (a / 32) * 32 + (a % 8) * 4 + (1 - (a / 16) % 2) * 2 + (a / 8) % 2;
    else valid = 0;
  endfunction

  function automatic string req_of(int code);
    if (code >= 64) return "R4";
    if (code >= 16) return "R5";
    if (code == 4 || code == 5 || code == 6) return "R1";
    if (code == 0 || code == 2) return "R2";
    if (code == 8) return "R3";
    return "R7";
  endfunction

  task automatic one_write(int code, longint a, logic [7:0] d, logic act, logic wr);
    longint eb;
    bit v;
    bit vx;
    string rq;
    @(negedge clk);
    dl_index = 8'(code); dl_addr = 24'(a); dl_data = d; dl_active = act; dl_wr = wr;
    @(negedge clk);
    dl_wr = 1'b0;
    eb = exp_byte(code, a, v, vx);
    rq = req_of(code);
    if (!(act && wr)) begin
      check("R8 no strobe", sd_we, 0);
    end else if (!v) begin
      check("R7 unknown code", sd_we, 0);
    end else begin
      check({rq, " we"}, sd_we, 1);
      check({rq, " addr"}, sd_waddr, eb / 2);
      check("R5 voice flag", sd_voice, vx);
      check("R6 data", sd_wdata, {d, d});
      check("R6 mask", sd_dqm, (eb % 2 == 0) ? 2 : 1);
    end
    @(negedge clk);
    check("R8 single pulse", sd_we, 0);
  endtask

  initial begin
    rst_n = 1'b0; dl_active = 1'b0; dl_index = '0; dl_addr = '0; dl_data = '0; dl_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 we in reset", sd_we, 0);
    check("R10 core in reset", core_rst_n, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 released when idle", core_rst_n, 1);
    dl_active = 1'b1;
    @(negedge clk);
    check("R9 held in download", core_rst_n, 0);

    // Fix remap examples.
    one_write(8, 64'h00, 8'h11, 1, 1);
    check("R3 f(0x00)", sd_waddr, (64'h680000 + 2) / 2);
    one_write(8, 64'h08, 8'h22, 1, 1);
    check("R3 f(0x08) upper lane", sd_dqm, 2'b01);
    one_write(8, 64'h10, 8'h33, 1, 1);
    check("R3 f(0x10)", sd_waddr, 64'h680000 / 2);
    one_write(8, 64'h18, 8'h44, 1, 1);
    check("R3 f(0x18) upper lane", sd_dqm, 2'b01);

    // Sweep every code against several offsets.
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 5; k++) begin
        longint a;
        case (k)
          0: a = 0;
          1: a = 1;
          2: a = 64'h1F;
          3: a = 64'h2A5 + c;
          default: a = 64'h7FFFF - c;
        endcase
        one_write(c, a, 8'(c * 7 + k), 1, 1);
      end
    end

    // Strobe without download and download without strobe.
    one_write(4, 64'h10, 8'h5A, 0, 1);
    one_write(70, 64'h10, 8'hA5, 1, 0);

    dl_active = 1'b0;
    @(negedge clk);
    check("R9 released after download", core_rst_n, 1);
    rst_n = 1'b0;
    #1;
    check("R10 core on reset entry", core_rst_n, 0);
    check("R10 we on reset entry", sd_we, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule